// File: doc/BRIEF.md
# Video Memory Mirroring Decoder

This block sits between a video engine's address bus and its memories. Each access carries an address, a write flag, write data and a mirroring-mode code. The block masks the address to the 14-bit video space and sends the access to one of three targets:

- an external cartridge pattern memory, reached through a request/data port;
- an internal 2 KB nametable RAM;
- an internal 32-byte palette RAM.

Nametable accesses pass through a mode-selected fold. The fold maps four logical 1 KB tables onto the two physical kilobytes of RAM. Palette accesses pass through an alias rule: the first entry of each sprite palette group lands on the matching background entry. Both RAMs are synchronous. Read data returns one cycle after the request, together with a valid strobe. The pattern port is expected to answer a read in the cycle after its request, on the same timing.

Top module: `vmem_map_decoder`

## Requirements
- R1: Address bits above bit 13 are ignored. An access to address A behaves exactly like an access to A AND 0x3FFF, and `pat_addr_o` carries bits [12:0] of the masked address.
- R2: A masked address in 0x0000–0x1FFF asserts `pat_req_o` in the same cycle, with `pat_we_o` equal to the write flag and `pat_wdata_o` equal to the write data. Read data from `pat_rdata_i` appears on `rdata_o` one cycle later.
- R3: A masked address in 0x2000–0x3EFF reaches the nametable RAM using the offset (A − 0x2000) AND 0xFFF. As a result, 0x3000–0x3EFF reads and writes the same bytes as 0x2000–0x2EFF.
- R4: The nametable offset bits [11:10] select logical table T (0–3), and bits [9:0] select the byte within it. With mode code 0, tables 0 and 1 share physical table 0, and tables 2 and 3 share physical table 1.
- R5: With mode code 1, tables 0 and 2 share physical table 0, and tables 1 and 3 share physical table 1.
- R6: Mode code 2 maps all four tables to physical table 0. Mode code 3 maps all four tables to physical table 1.
- R7: Mode codes 4 to 7 keep T unchanged before the physical index is cut to 11 bits. So T=2 lands on physical table 0 and T=3 lands on physical table 1.
- R8: A masked address in 0x3F00–0x3FFF reaches the palette RAM at offset (A − 0x3F00) AND 0x1F, so the 32 entries repeat every 32 bytes.
- R9: A palette offset of 0x10, 0x14, 0x18 or 0x1C is replaced by that offset minus 0x10, for both reads and writes.
- R10: After every read request, `rvalid_o` is high for exactly one cycle, in the cycle after the request. A write never raises `rvalid_o`. Reset clears `rvalid_o`.
- R11: An access whose masked address is 0x2000 or above never raises `pat_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Access address (only bits [13:0] used) |
| wdata_i | input | 8 | Write data |
| mode_i | input | 3 | Nametable mirroring mode code, sampled with each access |
| rdata_o | output | 8 | Read data, valid when `rvalid_o` is high |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| pat_req_o | output | 1 | Pattern-port request |
| pat_we_o | output | 1 | Pattern-port write flag |
| pat_addr_o | output | 13 | Pattern-port address |
| pat_wdata_o | output | 8 | Pattern-port write data |
| pat_rdata_i | input | 8 | Pattern-port read data, one cycle after a read request |

## Verification
For every mode code 0–7, the bench writes a distinct byte into each of the four logical tables at the same offset, then reads all four back. The value each table returns shows which physical table the mode folded it onto. The single-table modes return the last write everywhere, and the pair modes split the four tables differently. The same reads repeated through the 0x3000 mirror, and through addresses with the top bits set, separate correct masking from decoding the full address. Writing all 32 palette offsets in order and reading them back shows the four alias slots returning the later sprite-side write while the other slots keep their own bytes. Pattern-port traffic is checked for routing at the port itself and for its one-cycle read return.

// File: rtl/vmem_map_pkg.sv
package vmem_map_pkg;

  localparam int VA_W      = 14;
  localparam int PAT_AW    = 13;
  localparam int NT_OFF_W  = 12;
  localparam int MODE_W    = 3;
  localparam logic [VA_W-1:0] NT_BASE  = 14'h2000;
  localparam logic [VA_W-1:0] PAL_BASE = 14'h3F00;

  typedef enum logic [1:0] {
    TGT_PAT = 2'd0,
    TGT_NT  = 2'd1,
    TGT_PAL = 2'd2
  } tgt_e;

  // logical table -> physical table for a mode code; codes above 4 act as 4
  function automatic logic [1:0] mir_map(logic [MODE_W-1:0] mode, logic [1:0] tbl);
    case (mode)
      3'd0:    return {1'b0, tbl[1]};
      3'd1:    return {1'b0, tbl[0]};
      3'd2:    return 2'd0;
      3'd3:    return 2'd1;
      default: return tbl;
    endcase
  endfunction

endpackage

// File: rtl/vmem_sync_ram.sv
module vmem_sync_ram #(
  parameter int DEPTH  = 2048,
  parameter int WIDTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  // contents are left undefined by reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_q <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/vmem_addr_route.sv
module vmem_addr_route
  import vmem_map_pkg::*;
#(
  parameter int IN_AW  = 16,
  parameter int PAL_AW = 5
) (
  input  logic [IN_AW-1:0]    addr_i,
  output tgt_e                tgt_o,
  output logic [PAT_AW-1:0]   pat_addr_o,
  output logic [NT_OFF_W-1:0] nt_off_o,
  output logic [PAL_AW-1:0]   pal_off_o
);

  logic [VA_W-1:0] va;
  logic [VA_W-1:0] nt_diff;
  logic [VA_W-1:0] pal_diff;
  logic            unused_bits;

  assign va       = addr_i[VA_W-1:0];
  assign nt_diff  = va - NT_BASE;
  assign pal_diff = va - PAL_BASE;

  assign pat_addr_o = va[PAT_AW-1:0];
  assign nt_off_o   = nt_diff[NT_OFF_W-1:0];
  assign pal_off_o  = pal_diff[PAL_AW-1:0];

  assign unused_bits = ^{addr_i[IN_AW-1:VA_W], nt_diff[VA_W-1:NT_OFF_W],
                         pal_diff[VA_W-1:PAL_AW]};

  always_comb begin
    if (!va[VA_W-1])
      tgt_o = TGT_PAT;
    else if (va[VA_W-1:8] == PAL_BASE[VA_W-1:8])
      tgt_o = TGT_PAL;
    else
      tgt_o = TGT_NT;
  end

endmodule

// File: rtl/vmem_nt_fold.sv
module vmem_nt_fold
  import vmem_map_pkg::*;
#(
  parameter int TBL_OFF_W = 10,
  parameter int NT_AW     = 11,
  localparam int OFF_W    = TBL_OFF_W + 2
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [NT_AW-1:0]  phys_o
);

  logic [1:0]       lut [4];
  logic [1:0]       logical;
  logic [OFF_W-1:0] full;
  logic             unused_top;

  for (genvar i = 0; i < 4; i++) begin : g_tbl
    assign lut[i] = mir_map(mode_i, 2'(i));
  end

  assign logical    = off_i[OFF_W-1:TBL_OFF_W];
  assign full       = {lut[logical], off_i[TBL_OFF_W-1:0]};
  // cut to RAM size: in the four-table mode, tables 2/3 wrap onto 0/1
  assign phys_o     = full[NT_AW-1:0];
  assign unused_top = ^full[OFF_W-1:NT_AW];

endmodule

// File: rtl/vmem_pal_alias.sv
module vmem_pal_alias #(
  parameter int PAL_AW = 5
) (
  input  logic [PAL_AW-1:0] off_i,
  output logic [PAL_AW-1:0] idx_o
);

  logic hit;

  // first entry of each upper-half group folds onto the lower half
  assign hit   = off_i[PAL_AW-1] && (off_i[1:0] == 2'b00);
  assign idx_o = hit ? {1'b0, off_i[PAL_AW-2:0]} : off_i;

endmodule

// File: rtl/vmem_map_decoder.sv
module vmem_map_decoder
  import vmem_map_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IN_AW     = 16,
  parameter int TBL_BYTES = 1024,
  parameter int NT_BYTES  = 2048,
  parameter int PAL_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [IN_AW-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              pat_req_o,
  output logic              pat_we_o,
  output logic [PAT_AW-1:0] pat_addr_o,
  output logic [DATA_W-1:0] pat_wdata_o,
  input  logic [DATA_W-1:0] pat_rdata_i
);

  localparam int TBL_OFF_W = $clog2(TBL_BYTES);
  localparam int NT_AW     = $clog2(NT_BYTES);
  localparam int PAL_AW    = $clog2(PAL_BYTES);

  tgt_e                tgt;
  logic [NT_OFF_W-1:0] nt_off;
  logic [PAL_AW-1:0]   pal_off;
  logic [PAL_AW-1:0]   pal_idx;
  logic [NT_AW-1:0]    nt_idx;
  logic [DATA_W-1:0]   nt_rd;
  logic [DATA_W-1:0]   pal_rd;
  logic                nt_we, nt_re, pal_we, pal_re;
  logic                rvalid_q;
  tgt_e                sel_q;

  vmem_addr_route #(
    .IN_AW  (IN_AW),
    .PAL_AW (PAL_AW)
  ) route_i (
    .addr_i     (addr_i),
    .tgt_o      (tgt),
    .pat_addr_o (pat_addr_o),
    .nt_off_o   (nt_off),
    .pal_off_o  (pal_off)
  );

  vmem_nt_fold #(
    .TBL_OFF_W (TBL_OFF_W),
    .NT_AW     (NT_AW)
  ) fold_i (
    .mode_i (mode_i),
    .off_i  (nt_off),
    .phys_o (nt_idx)
  );

  vmem_pal_alias #(
    .PAL_AW (PAL_AW)
  ) alias_i (
    .off_i (pal_off),
    .idx_o (pal_idx)
  );

  assign nt_we  = req_i &  we_i & (tgt == TGT_NT);
  assign nt_re  = req_i & ~we_i & (tgt == TGT_NT);
  assign pal_we = req_i &  we_i & (tgt == TGT_PAL);
  assign pal_re = req_i & ~we_i & (tgt == TGT_PAL);

  vmem_sync_ram #(
    .DEPTH (NT_BYTES),
    .WIDTH (DATA_W)
  ) nt_ram_i (
    .clk_i   (clk_i),
    .we_i    (nt_we),
    .re_i    (nt_re),
    .addr_i  (nt_idx),
    .wdata_i (wdata_i),
    .rdata_o (nt_rd)
  );

  vmem_sync_ram #(
    .DEPTH (PAL_BYTES),
    .WIDTH (DATA_W)
  ) pal_ram_i (
    .clk_i   (clk_i),
    .we_i    (pal_we),
    .re_i    (pal_re),
    .addr_i  (pal_idx),
    .wdata_i (wdata_i),
    .rdata_o (pal_rd)
  );

  assign pat_req_o   = req_i & (tgt == TGT_PAT);
  assign pat_we_o    = pat_req_o & we_i;
  assign pat_wdata_o = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      sel_q    <= TGT_PAT;
    end else begin
      rvalid_q <= req_i & ~we_i;
      if (req_i & ~we_i) sel_q <= tgt;
    end
  end

  always_comb begin
    case (sel_q)
      TGT_NT:  rdata_o = nt_rd;
      TGT_PAL: rdata_o = pal_rd;
      default: rdata_o = pat_rdata_i;
    endcase
  end

  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/vmem_map_decoder_chk.sv
module vmem_map_decoder_chk #(
  parameter int DATA_W = 8,
  parameter int IN_AW  = 16,
  parameter int PAT_AW = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [IN_AW-1:0]  addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rvalid_o,
  input logic              pat_req_o,
  input logic              pat_we_o,
  input logic [PAT_AW-1:0] pat_addr_o,
  input logic [DATA_W-1:0] pat_wdata_o
);

  logic unused_hi;
  assign unused_hi = ^addr_i[IN_AW-1:14];

  assert_pat_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_req_o |-> (pat_addr_o == addr_i[PAT_AW-1:0]));

  assert_pat_route_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !addr_i[13]) |-> pat_req_o);

  assert_pat_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_req_o |-> ((pat_we_o == we_i) && (!we_i || pat_wdata_o == wdata_i)));

  assert_no_pat_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[13]) |-> !pat_req_o);

  assert_rvalid_next_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  assert_rvalid_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i));

endmodule

bind vmem_map_decoder vmem_map_decoder_chk #(
  .DATA_W (8),
  .IN_AW  (16),
  .PAT_AW (13)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rvalid_o    (rvalid_o),
  .pat_req_o   (pat_req_o),
  .pat_we_o    (pat_we_o),
  .pat_addr_o  (pat_addr_o),
  .pat_wdata_o (pat_wdata_o)
);

// File: tb/vmem_map_decoder_tb_top.sv
`timescale 1ns/1ps
module vmem_map_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [2:0]  mode = '0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic        pat_req, pat_we;
  logic [12:0] pat_addr;
  logic [7:0]  pat_wdata;
  logic [7:0]  pat_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] pmem   [8192];
  logic [7:0] nt_ref [2048];
  logic [7:0] pal_ref[32];
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  vmem_map_decoder dut_i (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we),
    .addr_i (addr), .wdata_i (wdata), .mode_i (mode),
    .rdata_o (rdata), .rvalid_o (rvalid),
    .pat_req_o (pat_req), .pat_we_o (pat_we), .pat_addr_o (pat_addr),
    .pat_wdata_o (pat_wdata), .pat_rdata_i (pat_rdata)
  );

  // external pattern memory: answers the cycle after a read request
  always @(posedge clk) begin
    if (pat_req) begin
      if (pat_we) pmem[pat_addr] <= pat_wdata;
      else        pat_rdata <= pmem[pat_addr];
    end
  end

  task automatic check(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  function automatic int nt_phys(input int m, input int a);
    int o, t, p;
    o = ((a & 'h3FFF) - 'h2000) & 'hFFF;
    t = o >> 10;
    case (m)
      0: p = t >> 1;
      1: p = t & 1;
      2: p = 0;
      3: p = 1;
      default: p = t;
    endcase
    return ((p << 10) + (o & 'h3FF)) & 'h7FF;
  endfunction

  function automatic int pal_idx(input int a);
    int o;
    o = ((a & 'h3FFF) - 'h3F00) & 'h1F;
    if (o >= 'h10 && (o & 3) == 0) o = o - 'h10;
    return o;
  endfunction

  // monitor: pops one expected item per valid read result
  always @(negedge clk) begin
    logic [7:0] e;
    string t;
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected rvalid", 1, 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata == e, t, rdata, e);
      end
    end
  end

  // driver: one access per cycle, called at a falling edge
  task automatic acc(input logic [15:0] a, input bit w, input logic [7:0] d,
                     input logic [2:0] m, input logic [7:0] e, input string r);
    bit to_pat;
    req = 1'b1; we = w; addr = a; wdata = d; mode = m;
    if (!w) begin exp_q.push_back(e); tag_q.push_back(r); end
    to_pat = (a[13] == 1'b0);
    #2;
    if (to_pat) begin
      check(pat_req == 1'b1, "R2 pat_req", pat_req, 1);
      check(pat_addr == a[12:0], "R1 pat_addr", pat_addr, a[12:0]);
      check(pat_we == w, "R2 pat_we", pat_we, w);
    end else begin
      check(pat_req == 1'b0, "R11 pat_req", pat_req, 0);
    end
    @(negedge clk);
    if (w) check(rvalid == 1'b0, "R10 rvalid after write", rvalid, 0);
  endtask

  task automatic idle();
    req = 1'b0; we = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rvalid == 1'b0, "R10 reset rvalid", rvalid, 0);
    check(pat_req == 1'b0, "R2 reset pat_req", pat_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // pattern port
    acc(16'hC123, 1, 8'h5A, 3'd0, 8'h00, "R1");
    acc(16'h1FFF, 1, 8'hA7, 3'd0, 8'h00, "R2");
    acc(16'h0123, 0, 8'h00, 3'd0, 8'h5A, "R2 pattern read");
    acc(16'h4123, 0, 8'h00, 3'd0, 8'h5A, "R1 masked pattern read");
    acc(16'h1FFF, 0, 8'h00, 3'd0, 8'hA7, "R2 pattern read top");

    // nametable fold per mode
    for (int m = 0; m < 8; m++) begin
      int off = m * 8 + 3;
      string r;
      case (m)
        0: r = "R4 mode0";
        1: r = "R5 mode1";
        2, 3: r = "R6 single";
        default: r = "R7 four-table";
      endcase
      for (int t = 0; t < 4; t++) begin
        int a = 'h2000 + t * 'h400 + off;
        nt_ref[nt_phys(m, a)] = 8'(m * 16 + t + 1);
        acc(16'(a), 1, 8'(m * 16 + t + 1), 3'(m), 8'h00, r);
      end
      for (int t = 0; t < 4; t++) begin
        int a = 'h2000 + t * 'h400 + off;
        acc(16'(a), 0, 8'h00, 3'(m), nt_ref[nt_phys(m, a)], r);
      end
      for (int t = 0; t < 4; t++) begin
        int a = 'h3000 + t * 'h400 + off;
        acc(16'(a), 0, 8'h00, 3'(m), nt_ref[nt_phys(m, a)], "R3 mirror");
      end
    end
    acc(16'hE000 + 16'd35, 0, 8'h00, 3'd4, nt_ref[nt_phys(4, 'h2000 + 35)], "R1 nametable");

    // palette
    for (int i = 0; i < 32; i++) begin
      pal_ref[pal_idx('h3F00 + i)] = 8'('h80 + i);
      acc(16'('h3F00 + i), 1, 8'('h80 + i), 3'd0, 8'h00, "R8");
    end
    for (int i = 0; i < 32; i++) begin
      string r = (i >= 16 && (i % 4) == 0) ? "R9 alias" : "R8 palette";
      acc(16'('h3F00 + i), 0, 8'h00, 3'd0, pal_ref[pal_idx('h3F00 + i)], r);
    end
    acc(16'h3FE4, 0, 8'h00, 3'd0, pal_ref[4], "R8 wrap");
    acc(16'hFF10, 0, 8'h00, 3'd0, pal_ref[0], "R1 palette");
    pal_ref[pal_idx('h3F1C)] = 8'h3C;
    acc(16'h3F1C, 1, 8'h3C, 3'd0, 8'h00, "R9");
    acc(16'h3F0C, 0, 8'h00, 3'd0, 8'h3C, "R9 alias write");
    acc(16'h3F1D, 0, 8'h00, 3'd0, pal_ref[29], "R9 non-alias");

    idle();
    idle();
    check(exp_q.size() == 0, "R10 pending reads", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R10: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule